// File: doc/BRIEF.md
# Strobed Parallel Register Port

This block is a clocked slave that puts a bank of eight 8-bit registers behind an asynchronous host port. The port has an active-low select, separate active-low read and write strobes, a 3-bit address and a data bus. The bus is split into an input, an output and an output-enable signal, so the pad and its tri-state buffer stay outside the block. The host strobes are not related to the block clock. Two flip-flops synchronise each strobe, and the address and data go through a two-stage pipeline alongside them.

A host can frame an access with either signal. It can pulse the strobe while select is held low, or pulse select while the strobe is held low. The edges may also come in any mixed order.

A write is counted while select and the write strobe are low together. The register is committed when the write strobe rises, using the address and data seen on the cycle before that rise. A write whose overlap is too short is dropped and sets a sticky error flag. Read data is driven while select and the read strobe are both low, after the synchronising delay. If both strobes are low at once with select low, the block performs neither access.

Top module: `strb_regport`

## Requirements
- R1: After reset all eight registers hold zero, and `bus_oe`, `bus_out` and `wr_err` are 0.
- R2: With `sel_n` held low, a `wr_n` low pulse that overlaps select for at least `MIN_OVL` synchronised clock cycles writes `bus_in` into the register at `addr` (default `MIN_OVL` = 3).
- R3: A select-framed write is accepted. Here `sel_n` pulses low for at least `MIN_OVL` cycles while `wr_n` is held low, and may rise before `wr_n` does. The register is still written when `wr_n` later rises, with the address and data present when `wr_n` rises.
- R4: A register only changes on the fourth rising clock edge after the edge at which `wr_n` is first sampled high, counting that edge as the first.
- R5: A write whose overlap of low `sel_n` and low `wr_n` lasts between 1 and `MIN_OVL`-1 cycles leaves the register unchanged and sets `wr_err`. `wr_err` then stays 1 until reset.
- R6: `bus_oe` equals the value of (`sel_n`=0 and `rd_n`=0 and `wr_n`=1) as it was sampled two rising clock edges earlier. The same rule applies whichever of `sel_n` and `rd_n` falls last or rises first.
- R7: While `bus_oe` is 1, `bus_out` shows the register at `addr`. While `bus_oe` is 0, `bus_out` is 0.
- R8: With `sel_n` held low, each separate `rd_n` low pulse produces its own `bus_oe` high interval with valid data.
- R9: If `sel_n`, `rd_n` and `wr_n` are all low together, `bus_oe` stays 0, no register is written and `wr_err` is not set.
- R10: Each of the eight addresses (0 to 7) selects its own read-write register, independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select from the host |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Register address |
| bus_in | input | DATA_W | Data arriving from the host bus |
| bus_out | output | DATA_W | Read data to the bus driver |
| bus_oe | output | 1 | Enable for the external bus driver |
| wr_err | output | 1 | Sticky flag for writes that were too short |

## Verification
A corrupted synchroniser or strobe-edge register shows up in `bus_oe`. The enable would rise or fall away from its fixed two-edge lag, and each read pulse is checked on the very cycle its enable rises.

A broken overlap counter or conflict guard has two visible symptoms. The first is a register value on the next read that differs from the one expected. The second is `wr_err` moving within four edges of the write strobe's rise.

A wrong write-hold capture puts the data in the wrong register. That error only becomes visible when the affected register is next read back.

// File: rtl/strb_regport.sv
module strb_regport #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int MIN_OVL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              wr_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(MIN_OVL + 1);

  logic [1:0] sel_p, rd_p, wr_p;
  logic [ADDR_W-1:0] a_p0, a_p1, hold_a;
  logic [DATA_W-1:0] d_p0, d_p1, hold_d;
  logic wr_q, spoil;
  logic [CW-1:0] ovl;
  logic [DEPTH-1:0][DATA_W-1:0] regs;

  wire sel_s   = sel_p[1];
  wire rd_s    = rd_p[1];
  wire wr_s    = wr_p[1];
  wire wr_rise = wr_s & ~wr_q;
  wire wr_act  = ~sel_s & ~wr_s & rd_s;
  wire clash   = ~sel_s & ~wr_s & ~rd_s;
  wire ovl_ok  = (ovl == CW'(MIN_OVL));
  wire commit  = wr_rise & ovl_ok & ~spoil;
  wire runt    = wr_rise & ~ovl_ok & (ovl != '0) & ~spoil;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_p <= 2'b11;
      rd_p  <= 2'b11;
      wr_p  <= 2'b11;
      wr_q  <= 1'b1;
      a_p0  <= '0;
      a_p1  <= '0;
      d_p0  <= '0;
      d_p1  <= '0;
    end else begin
      sel_p <= {sel_p[0], sel_n};
      rd_p  <= {rd_p[0], rd_n};
      wr_p  <= {wr_p[0], wr_n};
      wr_q  <= wr_s;
      a_p0  <= addr;
      a_p1  <= a_p0;
      d_p0  <= bus_in;
      d_p1  <= d_p0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_d <= '0;
    end else if (!wr_s) begin
      hold_a <= a_p1;
      hold_d <= d_p1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl   <= '0;
      spoil <= 1'b0;
    end else if (wr_s) begin
      ovl   <= '0;
      spoil <= 1'b0;
    end else begin
      if (wr_act && !ovl_ok) ovl <= ovl + 1'b1;
      if (clash) spoil <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs   <= '0;
      wr_err <= 1'b0;
    end else begin
      if (commit) regs[hold_a] <= hold_d;
      if (runt) wr_err <= 1'b1;
    end
  end

  assign bus_oe  = ~sel_s & ~rd_s & wr_s;
  assign bus_out = bus_oe ? regs[a_p1] : '0;
endmodule

module strb_regport_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             sel_n,
  input logic                             rd_n,
  input logic                             wr_n,
  input logic [DATA_W-1:0]                bus_out,
  input logic                             bus_oe,
  input logic                             wr_err,
  input logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs
);
  assert_oe_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe == $past(!sel_n && !rd_n && wr_n, 2));

  assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == '0);

  assert_write_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regs != $past(regs)) |-> ($past(wr_n, 3) && !$past(wr_n, 4)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_err) |-> wr_err);

  assert_err_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_err) |-> ($past(wr_n, 3) && !$past(wr_n, 4)));
endmodule

bind strb_regport strb_regport_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
  .bus_out(bus_out), .bus_oe(bus_oe), .wr_err(wr_err), .regs(regs)
);

// File: tb/strb_regport_test.sv
module strb_regport_test;
  logic clk = 0, rst_n = 0;
  logic sel_n = 1, rd_n = 1, wr_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] bus_in = 0, bus_out;
  logic bus_oe, wr_err;
  int checks = 0, fails = 0, rises = 0;
  bit oe_seen = 0, oe_prev = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] model[8];

  always #4 clk = ~clk;

  strb_regport uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .wr_err(wr_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_strobe(input logic [2:0] a, input logic [7:0] d, input int len, input bit keep);
    sel_n = 0; addr = a; bus_in = d; cyc(1);
    wr_n = 0; cyc(len);
    wr_n = 1; cyc(3);
    sel_n = 1; cyc(3);
    if (keep) model[a] = d;
  endtask

  task automatic wr_select(input logic [2:0] a, input logic [7:0] d);
    wr_n = 0; addr = a; bus_in = d; cyc(2);
    sel_n = 0; cyc(5);
    sel_n = 1; cyc(2);
    wr_n = 1; cyc(4);
    model[a] = d;
  endtask

  task automatic rd_strobe(input logic [2:0] a, input string tag);
    sel_n = 0; addr = a; exp_q.push_back(model[a]); tag_q.push_back(tag); cyc(1);
    rd_n = 0; cyc(5);
    rd_n = 1; cyc(3);
    sel_n = 1; cyc(3);
  endtask

  task automatic rd_select(input logic [2:0] a, input string tag);
    rd_n = 0; addr = a; exp_q.push_back(model[a]); tag_q.push_back(tag); cyc(2);
    sel_n = 0; cyc(5);
    sel_n = 1; cyc(2);
    rd_n = 1; cyc(3);
  endtask

  always @(negedge clk) begin
    if (bus_oe) oe_seen = 1;
    if (bus_oe && !oe_prev) begin
      rises++;
      if (exp_q.size() == 0) check(0, "R7 unexpected drive", bus_out, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_out === e, t, bus_out, e);
      end
    end
    if (!bus_oe) check(bus_out === 8'h00, "R7 idle bus", bus_out, 0);
    oe_prev = bus_oe;
  end

  initial begin
    #(8 * 100000);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    cyc(4); rst_n = 1; cyc(2);
    check(bus_oe === 0, "R1 oe", bus_oe, 0);
    check(wr_err === 0, "R1 err", wr_err, 0);
    rd_strobe(5, "R1 reset value");

    wr_strobe(0, 8'hA5, 6, 1);
    rd_strobe(0, "R2 strobe write");
    wr_select(7, 8'h3C);
    rd_strobe(7, "R3 select-framed write");
    rd_select(7, "R6 select-framed read");

    for (int i = 0; i < 8; i++) wr_strobe(i[2:0], 8'(i * 17 + 1), 4, 1);
    for (int i = 7; i >= 0; i--) rd_strobe(i[2:0], "R10 bank readback");

    sel_n = 0; addr = 1; cyc(1);
    rd_n = 0; cyc(1);
    check(bus_oe === 0, "R6 oe after one edge", bus_oe, 0);
    cyc(1);
    exp_q.push_back(model[1]); tag_q.push_back("R6 rise lag");
    check(bus_oe === 1, "R6 oe after two edges", bus_oe, 1);
    sel_n = 1; cyc(1);
    check(bus_oe === 1, "R6 oe holds one edge", bus_oe, 1);
    cyc(1);
    check(bus_oe === 0, "R6 oe drops two edges", bus_oe, 0);
    rd_n = 1; cyc(3);

    begin
      automatic int r0 = rises;
      sel_n = 0; addr = 2; cyc(1);
      for (int k = 0; k < 3; k++) begin
        exp_q.push_back(model[2]); tag_q.push_back("R8 burst read");
        rd_n = 0; cyc(4); rd_n = 1; cyc(4);
      end
      sel_n = 1; cyc(3);
      check(rises - r0 == 3, "R8 pulse count", rises - r0, 3);
    end

    oe_seen = 0;
    sel_n = 0; addr = 3; bus_in = 8'hFF; cyc(1);
    wr_n = 0; rd_n = 0; cyc(6);
    wr_n = 1; rd_n = 1; cyc(4);
    sel_n = 1; cyc(3);
    check(oe_seen == 0, "R9 no drive on clash", oe_seen, 0);
    check(wr_err === 0, "R9 no error on clash", wr_err, 0);
    rd_strobe(3, "R9 no write on clash");

    wr_strobe(4, 8'h77, 1, 0);
    check(wr_err === 1, "R5 runt sets error", wr_err, 1);
    rd_strobe(4, "R5 runt ignored");
    wr_strobe(4, 8'h66, 5, 1);
    check(wr_err === 1, "R5 error sticky", wr_err, 1);
    rd_strobe(4, "R5 later write ok");

    cyc(4);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule